// File: doc/BRIEF.md
# Serial Byte Receiver (8 data bits, no parity, one stop bit)

This block turns an asynchronous serial line into bytes. The line idles high. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line goes through a two-flop synchronizer. A bit-period counter then places one sample near the middle of every bit. When the stop bit is good, the byte appears on the data output with a one-clock strobe. When the stop bit is low, which covers both a framing error and a held-low break, a separate one-clock error strobe fires and the byte is dropped.

The bit period is a whole number of system clocks. It is derived at elaboration from the clock and baud parameters, rounded to the nearest clock. The checker prints the frame-length drift that this rounding causes, in thousandths of a bit over ten bits, next to an acceptance limit. The drift is zero when the clock is an exact multiple of the baud rate.

After a reset, or after a low stop bit, the receiver ignores the line until it has seen the line high. A line that is stuck low therefore cannot be taken as a stream of start bits.

Top module: `uart_rx_core`

## Requirements
- R1: Data bits are taken least significant bit first. Each bit is sampled once, at the clock that lies HALF + j·BIT clocks after the first clock that sees the start bit low. Here j = 1..8 is the bit number, BIT is the bit period and HALF = floor(BIT/2).
- R2: BIT = round(CLK_HZ / BAUD) clocks. BIT must be at least 4, so the fastest supported line rate is one quarter of the clock.
- R3: For a frame with a high stop bit, rxValid is high for exactly one clock and rxData holds the byte during that clock. That clock follows the rising edge F + 2 + HALF + 9·BIT, where F is the first edge at which the line is low. The two synchronizer stages are part of this latency.
- R4: For a frame with a low stop bit, rxBreak is high for exactly one clock at the same time as in R3. rxValid stays low, and rxData keeps the previous byte. rxValid and rxBreak are never high together.
- R5: After reset, the receiver ignores a low line until the line has been sampled high.
- R6: rst is synchronous and one clock of it is enough. It aborts any frame in progress, clears rxData to 0 and holds both strobes low.
- R7: A low pulse of at most HALF clocks is discarded at the start-bit midpoint. It produces no strobe, and the receiver returns to idle.
- R8: After a low stop bit, a line held low produces only one rxBreak. A new frame is accepted only after the line has gone high.
- R9: A stop bit of exactly BIT clocks may be followed at once by the next start bit, and both frames are received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxSerial | input | 1 | Asynchronous serial line, idles high |
| rxData | output | 8 | Last byte received without error |
| rxValid | output | 1 | One-clock strobe: rxData holds a new byte |
| rxBreak | output | 1 | One-clock strobe: stop bit was low (framing error or break) |

## Verification
The hardest cases to reach from the ports are the state the receiver is in after a reset while the line is low, and the state after a low stop bit. In both cases a receiver that arms too early shows nothing wrong until a stray frame completes. The stimulus therefore holds the line low for longer than a whole frame after reset. It also sends a low stop bit with nonzero data and a sustained break followed by a long low hold. In each case the bench expects silence until the line has risen and a fresh frame has been sent. Start-bit glitches of one clock and of exactly HALF clocks, and a reset in the middle of a frame, are placed at the boundary where the midpoint check decides.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // One-cycle commands from the control FSM to the datapath
  typedef struct packed {
    logic loadHalf;
    logic loadBit;
    logic shiftBit;
    logic acceptByte;
    logic rejectFrame;
  } rxStrobes_t;

  // Clocks per bit, rounded to nearest
  function automatic int bitCycles(int clkHz, int baud);
    return (clkHz + baud / 2) / baud;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  // Cleared to 0 so that reset never looks like an idle-high line
  always_ff @(posedge clk) begin
    if (rst) stageQ <= '0;
    else     stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLevel,
  input  logic       cntDone,
  output rxStrobes_t strobes
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rxState_t         state, stateNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;

  always_comb begin
    stateNext  = state;
    bitIdxNext = bitIdx;
    strobes    = '0;
    unique case (state)
      ST_ARM: begin
        if (rxLevel) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        // IDLE is only entered with the line high, so low here is a falling edge
        if (!rxLevel) begin
          strobes.loadHalf = 1'b1;
          stateNext        = ST_START;
        end
      end
      ST_START: begin
        if (cntDone) begin
          if (rxLevel) begin
            stateNext = ST_IDLE;
          end else begin
            strobes.loadBit = 1'b1;
            bitIdxNext      = '0;
            stateNext       = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (cntDone) begin
          strobes.shiftBit = 1'b1;
          strobes.loadBit  = 1'b1;
          if (bitIdx == LAST_IDX) stateNext = ST_STOP;
          else                    bitIdxNext = bitIdx + 1'b1;
        end
      end
      ST_STOP: begin
        if (cntDone) begin
          if (rxLevel) begin
            strobes.acceptByte = 1'b1;
            stateNext          = ST_IDLE;
          end else begin
            strobes.rejectFrame = 1'b1;
            stateNext           = ST_ARM;
          end
        end
      end
      default: stateNext = ST_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_ARM;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      bitIdx <= bitIdxNext;
    end
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLevel,
  input  rxStrobes_t        strobes,
  output logic              cntDone,
  output logic [DATA_W-1:0] dataOut,
  output logic              validOut,
  output logic              breakOut
);

  localparam int CNT_W = $clog2(BIT_CYCLES);
  localparam int HALF  = BIT_CYCLES / 2;
  localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LOAD  = CNT_W'(BIT_CYCLES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strobes.loadHalf) begin
      cnt <= HALF_LOAD;
    end else if (strobes.loadBit) begin
      cnt <= BIT_LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  // LSB arrives first and moves down toward bit 0
  always_ff @(posedge clk) begin
    if (rst)                   shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {rxLevel, shiftReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut  <= '0;
      validOut <= 1'b0;
      breakOut <= 1'b0;
    end else begin
      validOut <= strobes.acceptByte;
      breakOut <= strobes.rejectFrame;
      if (strobes.acceptByte) dataOut <= shiftReg;
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxSerial,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxBreak
);

  localparam int BIT_CYCLES = bitCycles(CLK_HZ, BAUD);

  logic       rxLevel;
  logic       cntDone;
  rxStrobes_t strobes;

  uart_rx_sync #(.STAGES(2)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (rxSerial),
    .syncOut (rxLevel)
  );

  uart_rx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rxLevel (rxLevel),
    .cntDone (cntDone),
    .strobes (strobes)
  );

  uart_rx_datapath #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .rxLevel  (rxLevel),
    .strobes  (strobes),
    .cntDone  (cntDone),
    .dataOut  (rxData),
    .validOut (rxValid),
    .breakOut (rxBreak)
  );

endmodule

// File: rtl/uart_rx_checks.sv
module uart_rx_checks
  import uart_rx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              rxBreak,
  input rxStrobes_t        strobes
);

  localparam int    BIT_CYCLES  = bitCycles(CLK_HZ, BAUD);
  localparam longint ERR_RAW    = longint'(BIT_CYCLES) * BAUD - CLK_HZ;
  localparam longint ERR_ABS    = (ERR_RAW < 0) ? -ERR_RAW : ERR_RAW;
  localparam longint DRIFT_MILLI = ERR_ABS * 10000 / CLK_HZ;
  localparam longint DRIFT_LIMIT = 250;

  initial begin
    $display("uart_rx_core: %0d clocks per bit, frame drift %0d/1000 bit, limit %0d/1000 bit",
             BIT_CYCLES, DRIFT_MILLI, DRIFT_LIMIT);
    if (BIT_CYCLES < 4 || DRIFT_MILLI > DRIFT_LIMIT)
      $display("uart_rx_core: WARNING clock to baud ratio out of range");
  end

  p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  p_accept_valid_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.acceptByte |=> rxValid);

  p_break_single_r4: assert property (@(posedge clk) disable iff (rst)
    rxBreak |=> !rxBreak);

  p_reject_break_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.rejectFrame |=> (rxBreak && !rxValid));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(rxValid && rxBreak));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rxData) && !$past(rst)) |-> rxValid);

  p_reset_quiet_r6: assert property (@(posedge clk)
    rst |=> (!rxValid && !rxBreak));

endmodule

bind uart_rx_core uart_rx_checks #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DATA_W)) i_checks (
  .clk     (clk),
  .rst     (rst),
  .rxData  (rxData),
  .rxValid (rxValid),
  .rxBreak (rxBreak),
  .strobes (strobes)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;

  localparam int CLK_HZ = 125_000_000;
  localparam int BAUD   = 31_250_000;
  localparam int BIT    = CLK_HZ / BAUD;   // 4 clocks: quarter-clock rate
  localparam int HALF   = BIT / 2;
  localparam int LAT    = 3 + HALF + 9 * BIT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxBreak;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  string curReq = "R6";

  int         evCycle[$];
  bit         evIsBreak[$];
  logic [7:0] evData[$];
  logic [7:0] expData = 8'h00;

  always #4 clk = ~clk;

  uart_rx_core #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) i_uart_rx_core (
    .clk      (clk),
    .rst      (rst),
    .rxSerial (rxd),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .rxBreak  (rxBreak)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      evCycle.delete();
      evIsBreak.delete();
      evData.delete();
      expData = 8'h00;
    end
  end

  // Reference comparison on every clock
  always @(negedge clk) begin
    bit   expV;
    bit   expB;
    expV = 1'b0;
    expB = 1'b0;
    if (evCycle.size() > 0 && evCycle[0] == cyc) begin
      if (evIsBreak[0]) expB = 1'b1;
      else begin
        expV    = 1'b1;
        expData = evData[0];
      end
      void'(evCycle.pop_front());
      void'(evIsBreak.pop_front());
      void'(evData.pop_front());
    end
    nChecks += 3;
    if (rxValid !== expV) begin
      nFails++;
      $display("FAIL %s: rxValid=%0b expected %0b at cycle %0d", curReq, rxValid, expV, cyc);
    end
    if (rxBreak !== expB) begin
      nFails++;
      $display("FAIL %s: rxBreak=%0b expected %0b at cycle %0d", curReq, rxBreak, expB, cyc);
    end
    if (rxData !== expData) begin
      nFails++;
      $display("FAIL %s: rxData=%02h expected %02h at cycle %0d", curReq, rxData, expData, cyc);
    end
  end

  task automatic drive(input bit v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit stopLvl);
    evCycle.push_back(cyc + LAT);
    evIsBreak.push_back(!stopLvl);
    evData.push_back(d);
    drive(1'b0, BIT);
    for (int i = 0; i < 8; i++) drive(d[i], BIT);
    drive(stopLvl, BIT);
  endtask

  task automatic pulseReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion before 200000 cycles");
    summary();
  end

  initial begin
    // R6: reset state, line low during reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5: line stays low well beyond a frame; nothing may start
    curReq = "R5";
    drive(1'b0, 60);
    drive(1'b1, 10);
    // R1 / R3: single frames, LSB first
    curReq = "R1";
    sendFrame(8'hA5, 1'b1);
    drive(1'b1, 6);
    curReq = "R3";
    sendFrame(8'h3C, 1'b1);
    drive(1'b1, 6);
    // R9: back-to-back frames
    curReq = "R9";
    sendFrame(8'h00, 1'b1);
    sendFrame(8'hFF, 1'b1);
    sendFrame(8'h81, 1'b1);
    drive(1'b1, 20);
    // R7: glitches of 1 and HALF clocks
    curReq = "R7";
    drive(1'b0, 1);
    drive(1'b1, 20);
    drive(1'b0, HALF);
    drive(1'b1, 20);
    sendFrame(8'h5A, 1'b1);
    drive(1'b1, 10);
    // R4: low stop bit with data; byte dropped, data kept
    curReq = "R4";
    sendFrame(8'hC3, 1'b0);
    drive(1'b1, 10);
    sendFrame(8'h12, 1'b1);
    drive(1'b1, 10);
    // R8: sustained break gives one strobe, then silence until line high
    curReq = "R8";
    evCycle.push_back(cyc + LAT);
    evIsBreak.push_back(1'b1);
    evData.push_back(8'h00);
    drive(1'b0, 30 * BIT);
    drive(1'b1, 10);
    sendFrame(8'h7E, 1'b1);
    drive(1'b1, 10);
    // R6: reset in mid-frame aborts it and clears data
    curReq = "R6";
    drive(1'b0, 3 * BIT);
    pulseReset();
    drive(1'b0, 4 * BIT);
    drive(1'b1, 20);
    sendFrame(8'h99, 1'b1);
    drive(1'b1, 10);
    // R2: exact bit period at the quarter-clock rate
    curReq = "R2";
    sendFrame(8'hE7, 1'b1);
    drive(1'b1, 50);
    summary();
  end

endmodule